// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block puts the command interface of a parallel NOR flash in front of a small on-chip byte array. A host reaches it through a synchronous port made of an address, a byte of write data, a write strobe, a read strobe and a byte of read data. Every write is treated as a command byte or as an argument, depending on where the block stands in a command sequence. A two-bit sequence step and the latched command decide two things: what the next write does, and whether reads return array bytes, the status byte or a byte of the built-in query table.

The supported operations are sector erase, buffered programming, the lock and unlock handshakes, status clear, status read and query mode. Erase walks through the addressed sector one byte per clock. While it runs, the ready bit reads low and bus writes are dropped. Programming happens in a single cycle for each byte written.

Top module: `nor_cmd_if`

## Requirements
- R1: Reset puts the block in array-read mode with a status byte of 0x80. The array contents survive reset.
- R2: A write of 0x70 while no sequence is open makes later reads return the status byte at any address. The next write is decoded as a new command.
- R3: A write of 0x50 while no sequence is open sets the status byte to 0x00 and returns the block to array-read mode.
- R4: Writing 0x20 and then 0xD0 at address A sets every byte from A with its low SECTOR_W bits cleared, up to that address plus 2**SECTOR_W minus 1, to 0xFF. Bytes outside that range keep their values. Status bit 7 reads 0 while the erase runs and 1 afterwards. Reads keep returning status until 0xFF is written.
- R5: After 0x20, any second write other than 0xD0 returns the block to array-read mode and erases nothing.
- R6: After 0xE8, reads return status and bit 7 is set. The next write's data is a count N. The following N+1 writes store their data bytes at their own addresses. A final 0xD0 returns the block to array-read mode with status bit 7 set.
- R7: If the byte ending a buffered program is anything other than 0xD0, the block returns to array-read mode and the bytes already stored stay in place.
- R8: After 0x60, reads return status. A second write of 0xD0 or 0x01 closes the sequence with status bit 7 set and status reads still selected. Any other second byte returns the block to array-read mode.
- R9: After 0x98, reads return the query-table entry at index = address[7:0] >> log2(DEV_BYTES). Indices 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59, index 0x13 holds 0x01, and index 0x27 holds ADDR_W. Indices of 0x31 and above read 0x00. Writes other than 0xFF leave query mode in place.
- R10: Writing 0xFF outside the count and data phases of a buffered program, or writing an unknown command byte while no sequence is open, returns the block to array-read mode. Inside those phases, 0xFF is stored as an ordinary count or data byte.
- R11: Bus writes that arrive while an erase is running have no effect on the array, the status byte or the command state.
- R12: Read data is registered. It is valid on the cycle after the read strobe and reflects the mode in force on the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Command, argument or data byte |
| wr | input | 1 | Write strobe, one transfer per cycle |
| rd | input | 1 | Read strobe, one transfer per cycle |
| rdata | output | 8 | Read result, valid the cycle after rd |

## Verification
Several properties are checked on every cycle. The ready bit stays low for the whole of an erase walk and is high when the walk ends. Writes during an erase leave the command state untouched. Clear status and 0xFF take effect on the next cycle. The data and confirm steps only exist under the buffered-program command. A status read returns the status byte from the strobe cycle. Other behaviour only the bench's scenarios can show: which bytes an erase actually reaches at the sector edges, that programmed data (including 0xFF) lands at its own address, the query-table contents and their zero fill, and the abort paths of each sequence back to array reads.

// File: rtl/nor_pkg.sv
package nor_pkg;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CLRSTAT = 8'h50;
  localparam logic [7:0] OP_PROTECT = 8'h60;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_BUFPGM  = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_PROTALT = 8'h01;

  localparam int QTAB_LEN = 49;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_QUERY  = 2'd2
  } src_t;
endpackage

// File: rtl/nor_array.sv
module nor_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [7:0]        wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic [7:0]        rq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/nor_qtab.sv
module nor_qtab #(
  parameter int ADDR_W   = 10,
  parameter int SECTOR_W = 6
) (
  input  logic [7:0] idx,
  output logic [7:0] val
);
  localparam int NBLK_M1  = (1 << (ADDR_W - SECTOR_W)) - 1;
  localparam int SECT_LEN = 1 << SECTOR_W;

  always_comb begin
    case (idx)
      8'h10: val = 8'h51;
      8'h11: val = 8'h52;
      8'h12: val = 8'h59;
      8'h13: val = 8'h01;
      8'h15: val = 8'h31;
      8'h1B: val = 8'h45;
      8'h1C: val = 8'h55;
      8'h1F: val = 8'h07;
      8'h20: val = 8'h07;
      8'h21: val = 8'h0A;
      8'h23: val = 8'h04;
      8'h24: val = 8'h04;
      8'h25: val = 8'h04;
      8'h27: val = 8'(ADDR_W);
      8'h28: val = 8'h02;
      8'h2A: val = 8'h04;
      8'h2C: val = 8'h01;
      8'h2D: val = 8'(NBLK_M1);
      8'h2E: val = 8'(NBLK_M1 >> 8);
      8'h2F: val = 8'(SECT_LEN >> 8);
      8'h30: val = 8'(SECT_LEN >> 16);
      default: val = 8'h00;
    endcase
  end
endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SECTOR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_wa,
  output logic [7:0]        mem_wd,
  output src_t              src,
  output logic [7:0]        status
);
  localparam int BASE_W = ADDR_W - SECTOR_W;

  logic [1:0]          step;
  logic [7:0]          cmd;
  logic [7:0]          remain;
  logic                wiping;
  logic [SECTOR_W-1:0] wipe_ptr;
  logic [BASE_W-1:0]   wipe_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      step      <= 2'd0;
      cmd       <= 8'h00;
      status    <= 8'h80;
      remain    <= 8'h00;
      wiping    <= 1'b0;
      wipe_ptr  <= '0;
      wipe_base <= '0;
    end else if (wiping) begin
      wipe_ptr <= wipe_ptr + SECTOR_W'(1);
      if (&wipe_ptr) begin
        wiping    <= 1'b0;
        status[7] <= 1'b1;
      end
    end else if (wr) begin
      case (step)
        2'd0: begin
          case (wdata)
            OP_ERASE:   begin cmd <= OP_ERASE;   step <= 2'd1; end
            OP_CLRSTAT: begin status <= 8'h00; cmd <= 8'h00; step <= 2'd0; end
            OP_PROTECT: begin cmd <= OP_PROTECT; step <= 2'd1; end
            OP_STATUS:  begin cmd <= OP_STATUS;  step <= 2'd0; end
            OP_QUERY:   begin cmd <= OP_QUERY;   step <= 2'd1; end
            OP_BUFPGM:  begin cmd <= OP_BUFPGM;  step <= 2'd1; status[7] <= 1'b1; end
            default:    begin cmd <= 8'h00;      step <= 2'd0; end
          endcase
        end
        2'd1: begin
          case (cmd)
            OP_ERASE: begin
              if (wdata == OP_CONFIRM) begin
                wiping    <= 1'b1;
                wipe_ptr  <= '0;
                wipe_base <= addr[ADDR_W-1:SECTOR_W];
                status[7] <= 1'b0;
                step      <= 2'd0;
              end else begin
                cmd <= 8'h00; step <= 2'd0;
              end
            end
            OP_BUFPGM: begin
              remain <= wdata;
              step   <= 2'd2;
            end
            OP_PROTECT: begin
              if (wdata == OP_CONFIRM || wdata == OP_PROTALT) begin
                step      <= 2'd0;
                status[7] <= 1'b1;
              end else begin
                cmd <= 8'h00; step <= 2'd0;
              end
            end
            OP_QUERY: begin
              if (wdata == OP_ARRAY) begin
                cmd <= 8'h00; step <= 2'd0;
              end
            end
            default: begin cmd <= 8'h00; step <= 2'd0; end
          endcase
        end
        2'd2: begin
          if (cmd == OP_BUFPGM) begin
            status[7] <= 1'b1;
            remain    <= remain - 8'd1;
            if (remain == 8'd0) step <= 2'd3;
          end else begin
            cmd <= 8'h00; step <= 2'd0;
          end
        end
        default: begin
          if (cmd == OP_BUFPGM && wdata == OP_CONFIRM) status[7] <= 1'b1;
          cmd  <= 8'h00;
          step <= 2'd0;
        end
      endcase
    end
  end

  always_comb begin
    mem_we = 1'b0;
    mem_wa = addr;
    mem_wd = wdata;
    if (wiping) begin
      mem_we = 1'b1;
      mem_wa = {wipe_base, wipe_ptr};
      mem_wd = 8'hFF;
    end else if (wr && step == 2'd2 && cmd == OP_BUFPGM) begin
      mem_we = 1'b1;
    end
  end

  always_comb begin
    case (cmd)
      OP_ERASE, OP_CLRSTAT, OP_PROTECT, OP_STATUS, OP_BUFPGM: src = SRC_STATUS;
      OP_QUERY: src = SRC_QUERY;
      default:  src = SRC_ARRAY;
    endcase
  end

  // R4: ready low for the whole walk
  p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (rst)
    wiping |-> !status[7]);

  // R4: ready back once the walk ends
  p_done_ready_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(wiping) |-> status[7]);

  // R11: writes during erase leave the command state alone
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (wiping && wr) |=> ($stable(step) && $stable(cmd)));

  // R3: clear status takes effect next cycle
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && !wiping && step == 2'd0 && wdata == OP_CLRSTAT)
      |=> (status == 8'h00 && src == SRC_ARRAY));

  // R10: 0xFF outside buffered phases returns to array reads
  p_ff_reset_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && !wiping && wdata == OP_ARRAY && cmd != OP_BUFPGM)
      |=> (step == 2'd0 && src == SRC_ARRAY));

  // R6: data and confirm steps exist only under buffered program
  p_buf_steps_r6: assert property (@(posedge clk) disable iff (rst)
    (step == 2'd2 || step == 2'd3) |-> cmd == OP_BUFPGM);
endmodule

// File: rtl/nor_cmd_if.sv
module nor_cmd_if
  import nor_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int SECTOR_W  = 6,
  parameter int DEV_BYTES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [7:0]        rdata
);
  localparam int IDX_SH = (DEV_BYTES == 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_wa;
  logic [7:0]        mem_wd;
  logic [7:0]        mem_q;
  src_t              src;
  logic [7:0]        status;
  logic [7:0]        q_idx;
  logic [7:0]        q_val;
  src_t              src_q;
  logic [7:0]        alt_q;

  nor_seq #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) u_seq (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wdata(wdata),
    .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd),
    .src(src), .status(status)
  );

  nor_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd),
    .re(rd), .ra(addr), .rq(mem_q)
  );

  assign q_idx = 8'(addr) >> IDX_SH;

  nor_qtab #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) u_qtab (
    .idx(q_idx), .val(q_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_ARRAY;
      alt_q <= 8'h00;
    end else if (rd) begin
      src_q <= src;
      alt_q <= (src == SRC_QUERY) ? q_val : status;
    end
  end

  assign rdata = (src_q == SRC_ARRAY) ? mem_q : alt_q;

  // R2/R12: a status read returns the status of the strobe cycle
  p_status_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd && src == SRC_STATUS) |=> rdata == $past(status));
endmodule

// File: tb/nor_cmd_if_tb.sv
`timescale 1ns/1ps
module nor_cmd_if_tb;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata;
  logic              wr;
  logic              rd;
  logic [7:0]        rdata;

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];
  logic  rd_seen = 1'b0;

  always #10 clk = ~clk;

  nor_cmd_if #(.ADDR_W(ADDR_W), .SECTOR_W(6), .DEV_BYTES(1)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .rdata(rdata)
  );

  // Monitor (R12): result compared on the cycle after the strobe
  always @(posedge clk) rd_seen <= rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12 unexpected read result actual=%02h expected=none", rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    addr = '0; wdata = 8'h00; wr = 1'b0; rd = 1'b0;
    @(negedge clk);
    do_reset();

    // R1 / R2: reset status, status mode at several addresses
    bus_wr(10'h000, 8'h70);
    bus_rd(10'h000, 8'h80, "R1 reset status");
    bus_rd(10'h2A7, 8'h80, "R2 status at any address");

    // R6: buffered program of four bytes, one of them 0xFF
    bus_wr(10'h040, 8'hE8);
    bus_rd(10'h040, 8'h80, "R6 status after setup");
    bus_wr(10'h040, 8'h03);
    bus_wr(10'h040, 8'h11);
    bus_wr(10'h041, 8'hFF);   // R10: 0xFF as data is stored
    bus_wr(10'h042, 8'h5A);
    bus_wr(10'h043, 8'hA5);
    bus_wr(10'h040, 8'hD0);
    bus_rd(10'h040, 8'h11, "R6 data byte 0");
    bus_rd(10'h041, 8'hFF, "R10 0xFF stored as data");
    bus_rd(10'h042, 8'h5A, "R6 data byte 2");
    bus_rd(10'h043, 8'hA5, "R6 data byte 3");

    // single-byte programs at sector 0 edges
    bus_wr(10'h03F, 8'hE8); bus_wr(10'h03F, 8'h00); bus_wr(10'h03F, 8'h12); bus_wr(10'h03F, 8'hD0);
    bus_wr(10'h000, 8'hE8); bus_wr(10'h000, 8'h00); bus_wr(10'h000, 8'h34); bus_wr(10'h000, 8'hD0);
    bus_rd(10'h03F, 8'h12, "R6 count zero program");
    bus_rd(10'h000, 8'h34, "R6 count zero program low");

    // R4 / R11: erase sector 0 via an address inside it
    bus_wr(10'h025, 8'h20);
    bus_wr(10'h025, 8'hD0);
    bus_rd(10'h025, 8'h00, "R4 busy status");
    bus_wr(10'h010, 8'h50);   // R11: dropped
    bus_wr(10'h010, 8'hFF);   // R11: dropped
    repeat (80) @(negedge clk);
    bus_rd(10'h010, 8'h80, "R11 writes during erase ignored");
    bus_wr(10'h000, 8'hFF);
    bus_rd(10'h000, 8'hFF, "R4 sector first byte erased");
    bus_rd(10'h025, 8'hFF, "R4 sector middle erased");
    bus_rd(10'h03F, 8'hFF, "R4 sector last byte erased");
    bus_rd(10'h040, 8'h11, "R4 next sector untouched");

    // R5: erase aborted
    bus_wr(10'h040, 8'h20);
    bus_wr(10'h040, 8'h42);
    repeat (80) @(negedge clk);
    bus_rd(10'h040, 8'h11, "R5 abort keeps data and array mode");

    // R3: clear status
    bus_wr(10'h000, 8'h50);
    bus_rd(10'h042, 8'h5A, "R3 array mode after clear");
    bus_wr(10'h000, 8'h70);
    bus_rd(10'h000, 8'h00, "R3 status cleared");

    // R8: lock and unlock handshakes
    bus_wr(10'h000, 8'h60);
    bus_rd(10'h000, 8'h00, "R8 status during setup");
    bus_wr(10'h000, 8'hD0);
    bus_rd(10'h000, 8'h80, "R8 confirm 0xD0 sets ready");
    bus_wr(10'h000, 8'h60);
    bus_wr(10'h000, 8'h01);
    bus_rd(10'h000, 8'h80, "R8 confirm 0x01 keeps status mode");
    bus_wr(10'h000, 8'h60);
    bus_wr(10'h000, 8'h33);
    bus_rd(10'h042, 8'h5A, "R8 bad second byte returns to array");

    // R9: query mode
    bus_wr(10'h000, 8'h98);
    bus_rd(10'h010, 8'h51, "R9 index 0x10");
    bus_rd(10'h011, 8'h52, "R9 index 0x11");
    bus_rd(10'h012, 8'h59, "R9 index 0x12");
    bus_rd(10'h013, 8'h01, "R9 index 0x13");
    bus_rd(10'h027, 8'h0A, "R9 index 0x27 size");
    bus_rd(10'h031, 8'h00, "R9 first index past table");
    bus_rd(10'h110, 8'h51, "R9 only low address byte used");
    bus_wr(10'h000, 8'h00);
    bus_rd(10'h012, 8'h59, "R9 other writes keep query mode");
    bus_wr(10'h000, 8'hFF);
    bus_rd(10'h040, 8'h11, "R10 0xFF leaves query mode");

    // R7: bad confirm after buffered data
    bus_wr(10'h050, 8'hE8); bus_wr(10'h050, 8'h00); bus_wr(10'h050, 8'h77); bus_wr(10'h050, 8'h00);
    bus_rd(10'h050, 8'h77, "R7 data kept, array mode");

    // R10: unknown command
    bus_wr(10'h000, 8'h70);
    bus_wr(10'h000, 8'h42);
    bus_rd(10'h043, 8'hA5, "R10 unknown command returns to array");

    // R1: second reset, array mode and contents kept
    do_reset();
    bus_rd(10'h040, 8'h11, "R1 array mode out of reset");
    bus_wr(10'h000, 8'h70);
    bus_rd(10'h000, 8'h80, "R1 status 0x80 after reset");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R12 missing read results actual=%0d expected=0", sb.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule